// File: doc/BRIEF.md
# Run-Length Bitstream Decompressor

This block turns a stream of compressed code bytes into a serial stream of configuration bits. Each byte selects one of four run shapes, picked by the range the byte falls in. One shape is a run of ones closed by a zero. Another is a long run of ones with no closing bit. A third is a run of zeros closed by a one. The last is a lone one. Code zero carries no bits and is only consumed.

Bytes enter through a valid/ready handshake. Bits leave one per cycle through a second valid/ready handshake that can stall at any time. The decoder works on one code at a time. It takes the next byte only after every bit of the current run has been handed off. A last marker sent with a byte is placed on the final bit of that byte's expansion. The run limit `RUN_LIMIT` (default 226) and the code width are parameters. All code boundaries are derived from them.

Top module: `rld_decompressor`

## Requirements
- R1: A code n with 1 <= n <= RUN_LIMIT (1..226 by default) produces n one-bits followed by exactly one zero-bit.
- R2: The code RUN_LIMIT+1 (227) produces exactly RUN_LIMIT (226) one-bits and no closing zero.
- R3: A code n with RUN_LIMIT+2 <= n <= 2^CODE_W-2 (228..254) produces n-(RUN_LIMIT+2) zero-bits followed by one one-bit, so code 228 gives a single one.
- R4: The all-ones code (255) produces a single one-bit.
- R5: Code 0 produces no output bit. The decoder is ready for a new code in the cycle after it is taken.
- R6: While a run is being emitted, `in_ready` is low. The next code is taken in the cycle after the final bit's handshake, so with the sink always ready the gap between two accepted codes is the first code's bit count plus one.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold their values into the next cycle.
- R8: `out_last` is high only on the final bit of a code accepted with `in_last` high. A last marker sent on code 0 is dropped.
- R9: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A code byte is offered |
| in_ready | output | 1 | The decoder takes the offered byte |
| in_code | input | CODE_W | Compressed code byte |
| in_last | input | 1 | Marks the byte as the end of a stream |
| out_valid | output | 1 | An expanded bit is offered |
| out_ready | input | 1 | The sink takes the offered bit |
| out_data | output | 1 | Expanded bit value |
| out_last | output | 1 | Final bit of a code accepted with its last marker |

## Verification
Codes are chosen at each edge of every range:
- 1, a small value and the run limit for terminated ones;
- the open ones code;
- the first, a middle and the highest zero-run code;
- the all-ones code.

Together these separate off-by-one errors in run length, a missing or extra closing bit, and a wrong range boundary. Each code is sent with the sink always ready, alternating and pseudo-random, so that stall handling shows up as corrupted or repeated bits. Code pairs sent back to back measure the acceptance gap. A null code carrying a last marker shows whether the marker leaks onto a later code.

// File: rtl/rld_pkg.sv
// Package: shared types for the run-length decompressor.
// Assumes: nothing beyond standard SystemVerilog.
package rld_pkg;

    // Shape selected by the range a code byte falls in
    typedef enum logic [2:0] {
        SHAPE_NONE       = 3'd0,   // code zero: nothing emitted
        SHAPE_ONES_TERM  = 3'd1,   // n ones, then one zero
        SHAPE_ONES_OPEN  = 3'd2,   // limit ones, no closing bit
        SHAPE_ZEROS_TERM = 3'd3,   // k zeros, then one one
        SHAPE_SINGLE_ONE = 3'd4    // lone one
    } run_shape_e;

endpackage

// File: rtl/rld_code_classify.sv
// Module: rld_code_classify
// Turns one code byte into a run description: the body bit, the body
// length and an optional closing bit. Purely combinational.
// Assumes: RUN_LIMIT + 2 <= 2**CODE_W - 1 and CNT_W holds RUN_LIMIT.
module rld_code_classify
    import rld_pkg::*;
#(
    parameter int CODE_W    = 8,
    parameter int RUN_LIMIT = 226,
    parameter int CNT_W     = 8
) (
    input  logic [CODE_W-1:0] code,
    output logic              body_bit,
    output logic [CNT_W-1:0]  body_len,
    output logic              close_en,
    output logic              close_bit
);

    localparam logic [CODE_W-1:0] LIMIT_C = CODE_W'(RUN_LIMIT);
    localparam logic [CODE_W-1:0] OPEN_C  = CODE_W'(RUN_LIMIT + 1);
    localparam logic [CODE_W-1:0] ZBASE_C = CODE_W'(RUN_LIMIT + 2);
    localparam logic [CODE_W-1:0] MAX_C   = {CODE_W{1'b1}};

    run_shape_e        shape;
    logic [CODE_W-1:0] zero_cnt;

    // Pick the shape from the code range
    always_comb begin
        if (code == '0)
            shape = SHAPE_NONE;
        else if (code <= LIMIT_C)
            shape = SHAPE_ONES_TERM;
        else if (code == OPEN_C)
            shape = SHAPE_ONES_OPEN;
        else if (code == MAX_C)
            shape = SHAPE_SINGLE_ONE;
        else
            shape = SHAPE_ZEROS_TERM;
    end

    // Length of the zero body for the zero-run range
    always_comb zero_cnt = code - ZBASE_C;

    // Map the shape to body and closing-bit fields
    always_comb begin
        body_bit  = 1'b1;
        body_len  = '0;
        close_en  = 1'b0;
        close_bit = 1'b0;
        unique case (shape)
            SHAPE_ONES_TERM: begin
                body_len  = CNT_W'(code);
                close_en  = 1'b1;
            end
            SHAPE_ONES_OPEN: begin
                body_len  = CNT_W'(RUN_LIMIT);
            end
            SHAPE_ZEROS_TERM: begin
                body_bit  = 1'b0;
                body_len  = CNT_W'(zero_cnt);
                close_en  = 1'b1;
                close_bit = 1'b1;
            end
            SHAPE_SINGLE_ONE: begin
                close_en  = 1'b1;
                close_bit = 1'b1;
            end
            default: begin
                body_len  = '0;
            end
        endcase
    end

endmodule

// File: rtl/rld_run_emitter.sv
// Module: rld_run_emitter
// Holds one run description and plays it out one bit per output handshake:
// first the body bits, then the closing bit if there is one.
// Assumes: load is only raised while busy is low.
module rld_run_emitter #(
    parameter int RUN_LIMIT = 226,
    parameter int CNT_W     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             ld_body_bit,
    input  logic [CNT_W-1:0] ld_body_len,
    input  logic             ld_close_en,
    input  logic             ld_close_bit,
    input  logic             ld_last,
    output logic             busy,
    output logic             out_valid,
    input  logic             out_ready,
    output logic             out_data,
    output logic             out_last
);

    logic [CNT_W-1:0] body_left;
    logic             close_pend;
    logic             body_bit_q;
    logic             close_bit_q;
    logic             last_q;
    logic             step;
    logic             final_bit;

    // A bit leaves when both sides agree
    always_comb step = out_valid && out_ready;

    // Load a new run, or count down the bits still to send
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            body_left   <= '0;
            close_pend  <= 1'b0;
            body_bit_q  <= 1'b0;
            close_bit_q <= 1'b0;
            last_q      <= 1'b0;
        end else if (load) begin
            body_left   <= ld_body_len;
            close_pend  <= ld_close_en;
            body_bit_q  <= ld_body_bit;
            close_bit_q <= ld_close_bit;
            last_q      <= ld_last;
        end else if (step) begin
            if (body_left != '0)
                body_left <= body_left - 1'b1;
            else
                close_pend <= 1'b0;
        end
    end

    // Present the current bit and mark the final one
    always_comb begin
        busy      = (body_left != '0) || close_pend;
        out_valid = busy;
        out_data  = (body_left != '0) ? body_bit_q : close_bit_q;
        final_bit = close_pend ? (body_left == '0) : (body_left == CNT_W'(1));
        out_last  = busy && last_q && final_bit;
    end

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    // R8
    last_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    // R6
    end_of_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> !out_valid);

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        body_left <= CNT_W'(RUN_LIMIT));

endmodule

// File: rtl/rld_decompressor.sv
// Module: rld_decompressor (top)
// Streams compressed code bytes in and expanded bits out. A byte is taken
// only while no run is in progress; its run then leaves one bit per
// output handshake.
// Assumes: RUN_LIMIT + 2 <= 2**CODE_W - 1.
module rld_decompressor #(
    parameter int CODE_W    = 8,
    parameter int RUN_LIMIT = 226
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [CODE_W-1:0] in_code,
    input  logic              in_last,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_data,
    output logic              out_last
);

    localparam int CNT_W = $clog2(RUN_LIMIT + 1);

    logic             cls_body_bit;
    logic [CNT_W-1:0] cls_body_len;
    logic             cls_close_en;
    logic             cls_close_bit;
    logic             run_busy;
    logic             take;

    // Accept a byte only between runs
    always_comb begin
        in_ready = !run_busy;
        take     = in_valid && in_ready;
    end

    rld_code_classify #(
        .CODE_W    (CODE_W),
        .RUN_LIMIT (RUN_LIMIT),
        .CNT_W     (CNT_W)
    ) classify_i (
        .code      (in_code),
        .body_bit  (cls_body_bit),
        .body_len  (cls_body_len),
        .close_en  (cls_close_en),
        .close_bit (cls_close_bit)
    );

    rld_run_emitter #(
        .RUN_LIMIT (RUN_LIMIT),
        .CNT_W     (CNT_W)
    ) emit_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (take),
        .ld_body_bit  (cls_body_bit),
        .ld_body_len  (cls_body_len),
        .ld_close_en  (cls_close_en),
        .ld_close_bit (cls_close_bit),
        .ld_last      (in_last),
        .busy         (run_busy),
        .out_valid    (out_valid),
        .out_ready    (out_ready),
        .out_data     (out_data),
        .out_last     (out_last)
    );

    // R5
    null_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && in_code == '0) |=> (!out_valid && in_ready));

    // R1
    ones_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && in_code != '0 && in_code <= CODE_W'(RUN_LIMIT)) |=> (out_valid && out_data));

    // R2
    open_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && in_code == CODE_W'(RUN_LIMIT + 1)) |=> (out_valid && out_data));

    // R3
    zero_run_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && in_code == CODE_W'(RUN_LIMIT + 2)) |=> (out_valid && out_data));

    // R4
    single_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && in_code == {CODE_W{1'b1}}) |=> (out_valid && out_data));

    // R6
    busy_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

endmodule

// File: tb/rld_decompressor_tb.sv
`timescale 1ns/1ps
module rld_decompressor_tb_top;

    localparam int LIM  = 226;
    localparam int CMAX = 255;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_code = '0;
    logic       in_last = 1'b0;
    logic       out_valid;
    logic       out_ready = 1'b0;
    logic       out_data;
    logic       out_last;

    int  total = 0;
    int  failed = 0;
    bit  finished = 0;
    logic [7:0] lfsr = 8'hA5;

    bit exp_b [0:1023];
    bit exp_l [0:1023];
    int exp_n;
    bit got_b [0:1023];
    bit got_l [0:1023];

    always #2.5 clk = ~clk;

    rld_decompressor #(.CODE_W(8), .RUN_LIMIT(LIM)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_code(in_code), .in_last(in_last),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
    );

    task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
        total++;
        if (!ok) begin
            failed++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic push(input bit b, input bit l);
        exp_b[exp_n] = b;
        exp_l[exp_n] = l;
        exp_n++;
    endtask

    // Expected expansion of one code, written from R1-R4 and R8 rules
    task automatic add_code(input int code, input bit last);
        if (code >= 1 && code <= LIM) begin
            for (int i = 0; i < code; i++) push(1'b1, 1'b0);
            push(1'b0, last);
        end else if (code == LIM + 1) begin
            for (int i = 0; i < LIM; i++) push(1'b1, last && (i == LIM - 1));
        end else if (code >= LIM + 2 && code <= CMAX - 1) begin
            for (int i = 0; i < code - (LIM + 2); i++) push(1'b0, 1'b0);
            push(1'b1, last);
        end else if (code == CMAX) begin
            push(1'b1, last);
        end
    endtask

    // Send one or two codes, collect the bits under a ready pattern, check all
    task automatic run_seq(input int c0, input bit l0, input int c1, input bit l1,
                           input int n, input int mode, input string tag);
        int idx = 0;
        bit hs = 0;
        int got = 0;
        int hs_cyc [0:1];
        int first_n;
        int stall_bad = 0, busy_bad = 0, bit_bad = 0, last_bad = 0, stalls = 0, tail_bad = 0;
        bit prev_stall = 0, prev_d = 0, prev_l = 0;
        exp_n = 0;
        add_code(c0, l0);
        first_n = exp_n;
        if (n > 1) add_code(c1, l1);
        hs_cyc[0] = -1; hs_cyc[1] = -1;
        @(negedge clk);
        in_valid = 1'b1; in_code = 8'(c0); in_last = l0;
        for (int cyc = 0; cyc < 2000; cyc++) begin
            if (hs) begin
                idx++; hs = 0;
                if (idx < n) begin in_code = 8'(c1); in_last = l1; end
                else begin in_valid = 1'b0; in_code = '0; in_last = 1'b0; end
            end
            if (in_valid && in_ready) begin hs = 1; hs_cyc[idx] = cyc; end
            out_ready = (mode == 0) ? 1'b1 : (mode == 1) ? ((cyc % 2) == 1) : (lfsr[0] ^ lfsr[2]);
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            if (prev_stall && (!out_valid || out_data != prev_d || out_last != prev_l)) stall_bad++;
            if (out_valid && in_ready) busy_bad++;
            if (out_valid && out_ready) begin
                if (got < 1024) begin got_b[got] = out_data; got_l[got] = out_last; end
                got++;
            end
            prev_stall = out_valid && !out_ready;
            if (prev_stall) stalls++;
            prev_d = out_data; prev_l = out_last;
            if (idx == n && !hs && got >= exp_n && !out_valid) break;
            @(negedge clk);
        end
        out_ready = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            if (out_valid || !in_ready) tail_bad++;
        end
        for (int k = 0; k < exp_n && k < got; k++) begin
            if (got_b[k] != exp_b[k]) bit_bad++;
            if (got_l[k] != exp_l[k]) last_bad++;
        end
        check(got == exp_n && bit_bad == 0 && tail_bad == 0, tag, "bit stream length", got, exp_n);
        check(bit_bad == 0, tag, "bit value mismatches", bit_bad, 0);
        check(last_bad == 0, "R8", "last marker mismatches", last_bad, 0);
        check(busy_bad == 0, "R6", "in_ready high during run", busy_bad, 0);
        if (stalls > 0) check(stall_bad == 0, "R7", "output changed under stall", stall_bad, 0);
        if (n > 1 && mode == 0)
            check(hs_cyc[1] - hs_cyc[0] == first_n + 1, "R6", "gap between accepted codes",
                  hs_cyc[1] - hs_cyc[0], first_n + 1);
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        in_valid = 1'b1; in_code = 8'd5;
        repeat (3) @(negedge clk);
        check(!out_valid, "R9", "out_valid in reset", out_valid, 0);
        in_valid = 1'b0; in_code = '0;
        rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid, "R9", "out_valid after reset", out_valid, 0);
        check(in_ready, "R9", "in_ready after reset", in_ready, 1);
    endtask

    task automatic test_r1_ones_term();
        run_seq(1, 1, 0, 0, 1, 0, "R1");
        run_seq(5, 1, 0, 0, 1, 1, "R1");
        run_seq(LIM, 1, 0, 0, 1, 2, "R1");
    endtask

    task automatic test_r2_open_run();
        run_seq(LIM + 1, 1, 0, 0, 1, 0, "R2");
        run_seq(LIM + 1, 1, 0, 0, 1, 2, "R2");
    endtask

    task automatic test_r3_zero_run();
        run_seq(LIM + 2, 1, 0, 0, 1, 0, "R3");
        run_seq(240, 1, 0, 0, 1, 1, "R3");
        run_seq(CMAX - 1, 1, 0, 0, 1, 2, "R3");
    endtask

    task automatic test_r4_single_one();
        run_seq(CMAX, 1, 0, 0, 1, 0, "R4");
    endtask

    task automatic test_r5_null_code();
        run_seq(0, 1, 3, 0, 2, 0, "R5");
    endtask

    task automatic test_r6_back_to_back();
        run_seq(7, 0, 250, 1, 2, 0, "R6");
        run_seq(LIM + 1, 0, 2, 1, 2, 0, "R6");
        run_seq(12, 1, CMAX, 1, 2, 2, "R6");
    endtask

    initial begin
        test_reset();
        test_r1_ones_term();
        test_r2_open_run();
        test_r3_zero_run();
        test_r4_single_one();
        test_r5_null_code();
        test_r6_back_to_back();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    end

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            finished = 1;
            total++;
            failed++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    end

endmodule